// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This block executes the signed 16x16 halfword multiply family for a processor datapath. Each cycle it may accept one decoded operation together with its operand values. It picks one 16-bit half from each 32-bit operand and multiplies the two halves as signed numbers. The operation field of the command word selects one of three forms. The multiply-only form returns the 32-bit product. The word-accumulate form adds the product to a 32-bit accumulator. The pair-accumulate form adds the sign-extended product to a 64-bit accumulator made of two 32-bit words.

The result, the write enables for the low and high destination words, and an illegal-operation indication are registered. They appear one cycle after the operation is accepted, marked by a one-cycle valid strobe. A sticky saturation flag records signed overflow from the word-accumulate form. The wrapped sum is still written unchanged. The flag is cleared only through its own clear input.

The registered output stage is a four-state machine:
- `OS_IDLE`: no result this cycle.
- `OS_WRITE`: a result is written.
- `OS_SKIP`: the condition failed, so the result is discarded.
- `OS_TRAP`: the operation was rejected as illegal.

On every clock edge the state moves to one of these four:
- to `OS_IDLE` when `in_valid` is low;
- otherwise to `OS_TRAP` when the command is illegal;
- otherwise to `OS_SKIP` when `cond_pass` is low;
- otherwise to `OS_WRITE`.

Top module: `hmac_unit`

## Requirements
- R1: Bit 5 of `op_fields` selects the half of `opnd_a` and bit 6 selects the half of `opnd_b`. A 1 takes bits 31:16 and a 0 takes bits 15:0. Either half is treated as a signed 16-bit value.
- R2: With `op_fields[27:20]` = 0x16 (multiply only), `res_lo` is the 32-bit signed product, `res_hi` is 0, `wr_lo`=1, `wr_hi`=0, and `q_flag` is unchanged.
- R3: With `op_fields[27:20]` = 0x10 (word accumulate), `res_lo` is the product plus `acc_lo` wrapped to 32 bits, `wr_lo`=1, `wr_hi`=0. A signed overflow of that sum sets `q_flag`.
- R4: With `op_fields[27:20]` = 0x14 (pair accumulate), {`res_hi`,`res_lo`} = {`acc_hi`,`acc_lo`} plus the product sign-extended to 64 bits. Both `wr_lo` and `wr_hi` are 1, and `q_flag` is unchanged.
- R5: A legal operation with `cond_pass` low still gives `res_valid`, but with `wr_lo`=`wr_hi`=0, both results 0 and `q_flag` unchanged.
- R6: The register fields are first operand [3:0], second operand [11:8], accumulator or low destination [15:12], and destination or high destination [19:16]. An operation is illegal if any field it uses equals 15, or if it is a pair accumulate with [19:16] equal to [15:12]. The multiply-only form does not use [15:12]. An illegal operation gives `illegal`=1, no write, zero results and an unchanged `q_flag`, whatever the value of `cond_pass`.
- R7: A command is also illegal if any of these holds: bits 27:20 are not one of 0x10, 0x14 or 0x16; bit 7 is 0; bit 4 is 1.
- R8: `res_valid` is high in exactly the cycle after each cycle with `in_valid` high, including back-to-back operations. It is low otherwise, and then `wr_lo`, `wr_hi` and `illegal` are also 0.
- R9: `q_flag` stays set until a cycle with `q_clear` high clears it. If an overflow and `q_clear` occur in the same cycle, the flag ends set.
- R10: After reset `res_valid`, `wr_lo`, `wr_hi`, `illegal` and `q_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| op_fields | input | 28 | Decoded command: operation, half selects, register fields |
| cond_pass | input | 1 | Condition evaluated true for this operation |
| opnd_a | input | 32 | First multiplicand word |
| opnd_b | input | 32 | Second multiplicand word |
| acc_lo | input | 32 | Word accumulator, or low word of the pair |
| acc_hi | input | 32 | High word of the pair accumulator |
| q_clear | input | 1 | Clears the sticky saturation flag |
| res_valid | output | 1 | Registered result strobe |
| res_lo | output | 32 | Result word, or low word of the pair |
| res_hi | output | 32 | High word of the pair result |
| wr_lo | output | 1 | Write enable for the low or single destination |
| wr_hi | output | 1 | Write enable for the high destination |
| illegal | output | 1 | Operation rejected |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions check on every cycle the control contract:
- the result strobe follows each accepted input by one cycle and never appears without one;
- a rejected operation writes nothing;
- a high-word write always comes with a low-word write;
- the saturation flag holds until cleared, and is left alone by condition-failed and multiply-only operations.

Only the bench's scenarios can show that the arithmetic is right. It sweeps every operation form, both half selections of both operands, a set of corner halfword values and accumulator values that do and do not overflow, and checks each result against sums computed in the bench. It also checks each illegal register combination one by one.

// File: rtl/hmac_pkg.sv
package hmac_pkg;

    // Operation form after decode
    typedef enum logic [1:0] {
        K_NONE,
        K_MUL,
        K_ACC32,
        K_ACC64
    } kind_e;

    // Registered output stage state
    typedef enum logic [1:0] {
        OS_IDLE,
        OS_WRITE,
        OS_SKIP,
        OS_TRAP
    } out_st_e;

    localparam logic [7:0] OPC_ACC32 = 8'h10;
    localparam logic [7:0] OPC_ACC64 = 8'h14;
    localparam logic [7:0] OPC_MUL   = 8'h16;

endpackage

// File: rtl/hmac_decode.sv
module hmac_decode
    import hmac_pkg::*;
#(
    parameter int REG_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic [4*REG_W+11:0] op_fields,
    output kind_e               kind,
    output logic                sel_a,
    output logic                sel_b,
    output logic                illegal
);
    localparam int CTL_LO = REG_W;
    localparam int RM_LO  = REG_W + 4;
    localparam int RA_LO  = 2*REG_W + 4;
    localparam int RD_LO  = 3*REG_W + 4;
    localparam int OPC_LO = 4*REG_W + 4;
    localparam logic [REG_W-1:0] PC_REG = REG_W'(PC_IDX);

    logic [REG_W-1:0] rn, rm, ra, rd;
    logic [3:0]       ctl;
    logic [7:0]       opc;
    logic             fmt_ok;

    assign rn  = op_fields[0      +: REG_W];
    assign ctl = op_fields[CTL_LO +: 4];
    assign rm  = op_fields[RM_LO  +: REG_W];
    assign ra  = op_fields[RA_LO  +: REG_W];
    assign rd  = op_fields[RD_LO  +: REG_W];
    assign opc = op_fields[OPC_LO +: 8];

    // ctl[3] must be 1, ctl[0] must be 0 (R7)
    assign fmt_ok = ctl[3] & ~ctl[0];
    assign sel_a  = ctl[1];
    assign sel_b  = ctl[2];

    always_comb begin
        kind = K_NONE;
        if (fmt_ok) begin
            unique case (opc)
                OPC_MUL:   kind = K_MUL;
                OPC_ACC32: kind = K_ACC32;
                OPC_ACC64: kind = K_ACC64;
                default:   kind = K_NONE;
            endcase
        end
    end

    // Register legality per form (R6)
    always_comb begin
        unique case (kind)
            K_MUL:   illegal = (rd == PC_REG) | (rm == PC_REG) | (rn == PC_REG);
            K_ACC32: illegal = (rd == PC_REG) | (ra == PC_REG) |
                               (rm == PC_REG) | (rn == PC_REG);
            K_ACC64: illegal = (rd == PC_REG) | (ra == PC_REG) |
                               (rm == PC_REG) | (rn == PC_REG) | (rd == ra);
            default: illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/hmac_datapath.sv
module hmac_datapath
    import hmac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic              sel_a,
    input  logic              sel_b,
    input  logic [DATA_W-1:0] acc_lo,
    input  logic [DATA_W-1:0] acc_hi,
    input  kind_e             kind,
    output logic [DATA_W-1:0] res_lo,
    output logic [DATA_W-1:0] res_hi,
    output logic              ovf
);
    localparam int HALF_W = DATA_W / 2;
    localparam int WIDE_W = 2 * DATA_W;
    localparam int NOPND  = 2;

    logic [DATA_W-1:0] words [NOPND];
    logic              sels  [NOPND];
    logic [DATA_W-1:0] ext   [NOPND];

    assign words[0] = opnd_a;
    assign words[1] = opnd_b;
    assign sels[0]  = sel_a;
    assign sels[1]  = sel_b;

    // Per-operand half pick and sign extension (R1)
    for (genvar g = 0; g < NOPND; g++) begin : g_half
        logic [HALF_W-1:0] half;
        assign half   = sels[g] ? words[g][DATA_W-1:HALF_W] : words[g][HALF_W-1:0];
        assign ext[g] = {{HALF_W{half[HALF_W-1]}}, half};
    end

    logic signed [DATA_W-1:0] prod;
    logic        [DATA_W-1:0] sum32;
    logic        [WIDE_W-1:0] sum64;

    assign prod  = $signed(ext[0]) * $signed(ext[1]);
    assign sum32 = prod + acc_lo;
    assign sum64 = {acc_hi, acc_lo} + {{DATA_W{prod[DATA_W-1]}}, prod};

    always_comb begin
        res_lo = '0;
        res_hi = '0;
        ovf    = 1'b0;
        unique case (kind)
            K_MUL: res_lo = prod;
            K_ACC32: begin
                res_lo = sum32;
                ovf    = (prod[DATA_W-1] == acc_lo[DATA_W-1]) &&
                         (sum32[DATA_W-1] != prod[DATA_W-1]);
            end
            K_ACC64: begin
                res_lo = sum64[DATA_W-1:0];
                res_hi = sum64[WIDE_W-1:DATA_W];
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hmac_unit.sv
module hmac_unit
    import hmac_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_W  = 4,
    parameter int PC_IDX = 15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [4*REG_W+11:0] op_fields,
    input  logic                cond_pass,
    input  logic [DATA_W-1:0]   opnd_a,
    input  logic [DATA_W-1:0]   opnd_b,
    input  logic [DATA_W-1:0]   acc_lo,
    input  logic [DATA_W-1:0]   acc_hi,
    input  logic                q_clear,
    output logic                res_valid,
    output logic [DATA_W-1:0]   res_lo,
    output logic [DATA_W-1:0]   res_hi,
    output logic                wr_lo,
    output logic                wr_hi,
    output logic                illegal,
    output logic                q_flag
);
    kind_e             kind, kind_q;
    logic              sel_a, sel_b, bad;
    logic [DATA_W-1:0] dp_lo, dp_hi;
    logic              dp_ovf, q_set, do_write;
    logic [DATA_W-1:0] res_lo_q, res_hi_q;
    out_st_e           state, state_nx;

    hmac_decode #(.REG_W(REG_W), .PC_IDX(PC_IDX)) u_decode (
        .op_fields (op_fields),
        .kind      (kind),
        .sel_a     (sel_a),
        .sel_b     (sel_b),
        .illegal   (bad)
    );

    hmac_datapath #(.DATA_W(DATA_W)) u_dp (
        .opnd_a (opnd_a),
        .opnd_b (opnd_b),
        .sel_a  (sel_a),
        .sel_b  (sel_b),
        .acc_lo (acc_lo),
        .acc_hi (acc_hi),
        .kind   (kind),
        .res_lo (dp_lo),
        .res_hi (dp_hi),
        .ovf    (dp_ovf)
    );

    // Next state of the output stage
    always_comb begin
        if (!in_valid)      state_nx = OS_IDLE;
        else if (bad)       state_nx = OS_TRAP;
        else if (!cond_pass) state_nx = OS_SKIP;
        else                state_nx = OS_WRITE;
    end

    assign do_write = (state_nx == OS_WRITE);
    assign q_set    = do_write && (kind == K_ACC32) && dp_ovf;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= OS_IDLE;
        else        state <= state_nx;
    end

    // Result registers: only written operations carry data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lo_q <= '0;
            res_hi_q <= '0;
            kind_q   <= K_NONE;
        end else if (do_write) begin
            res_lo_q <= dp_lo;
            res_hi_q <= dp_hi;
            kind_q   <= kind;
        end else begin
            res_lo_q <= '0;
            res_hi_q <= '0;
            kind_q   <= K_NONE;
        end
    end

    // Sticky saturation flag: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_flag <= 1'b0;
        else        q_flag <= (q_flag & ~q_clear) | q_set;
    end

    // Outputs decoded from the state
    always_comb begin
        res_valid = 1'b0;
        wr_lo     = 1'b0;
        wr_hi     = 1'b0;
        illegal   = 1'b0;
        unique case (state)
            OS_IDLE: ;
            OS_WRITE: begin
                res_valid = 1'b1;
                wr_lo     = 1'b1;
                wr_hi     = (kind_q == K_ACC64);
            end
            OS_SKIP: res_valid = 1'b1;
            OS_TRAP: begin
                res_valid = 1'b1;
                illegal   = 1'b1;
            end
            default: ;
        endcase
    end

    assign res_lo = res_lo_q;
    assign res_hi = res_hi_q;

    // Each accepted input yields a result strobe next cycle (R8)
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> res_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !wr_lo && !wr_hi && !illegal));
    // Rejected operations never write (R6)
    p_trap_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!wr_lo && !wr_hi));
    // High word only written together with low word (R4)
    p_pair_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |-> wr_lo);
    // Condition failure leaves the flag alone (R5)
    p_skip_keeps_q_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !cond_pass && !q_clear) |=> $stable(q_flag));
    // Multiply-only never moves the flag (R2)
    p_mul_keeps_q_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && kind == K_MUL && !q_clear) |=> $stable(q_flag));
    // Flag is sticky, and clears when nothing sets it (R9)
    p_q_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_flag && !q_clear) |=> q_flag);
    p_q_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q_clear && !in_valid) |=> !q_flag);

endmodule

// File: tb/hmac_unit_tb.sv
`timescale 1ns/1ps
module hmac_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [27:0] op_fields = '0;
    logic        cond_pass = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0, acc_lo = '0, acc_hi = '0;
    logic        q_clear = 1'b0;
    logic        res_valid, wr_lo, wr_hi, illegal, q_flag;
    logic [31:0] res_lo, res_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit q_model = 1'b0;

    always #10 clk = ~clk;

    hmac_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_fields(op_fields),
        .cond_pass(cond_pass), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .q_clear(q_clear),
        .res_valid(res_valid), .res_lo(res_lo), .res_hi(res_hi),
        .wr_lo(wr_lo), .wr_hi(wr_hi), .illegal(illegal), .q_flag(q_flag)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] mkw(input logic [7:0] opc, input bit x, input bit y,
                                        input logic [3:0] rd, ra, rm, rn);
        return {opc, rd, ra, rm, 1'b1, y, x, 1'b0, rn};
    endfunction

    function automatic logic [7:0] opc_of(input int kind);
        return (kind == 0) ? 8'h16 : (kind == 1) ? 8'h10 : 8'h14;
    endfunction

    // One operation; expectation computed from the requirements
    task automatic txn(input string req, input logic [27:0] w, input int kind,
                       input logic [31:0] a, b, alo, ahi, input bit cond, input bit legal);
        logic signed [15:0] sa, sb;
        int      ia, ib, p;
        longint  s, acc, r;
        logic [31:0] e_lo, e_hi;
        bit      wr, ov;
        @(negedge clk);
        op_fields = w; opnd_a = a; opnd_b = b; acc_lo = alo; acc_hi = ahi;
        cond_pass = cond; in_valid = 1'b1;
        sa = w[5] ? a[31:16] : a[15:0];
        sb = w[6] ? b[31:16] : b[15:0];
        ia = sa; ib = sb; p = ia * ib;
        e_lo = '0; e_hi = '0; ov = 1'b0;
        wr = legal && cond;
        if (kind == 0) e_lo = p;
        else if (kind == 1) begin
            s = longint'(p) + longint'($signed(alo));
            e_lo = s[31:0];
            ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
        end else begin
            acc = {ahi, alo};
            r = acc + longint'(p);
            e_lo = r[31:0]; e_hi = r[63:32];
        end
        if (!wr) begin e_lo = '0; e_hi = '0; end
        if (wr && kind == 1 && ov) q_model = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " ctl {valid,wr_lo,wr_hi,illegal,q}"},
            {59'd0, res_valid, wr_lo, wr_hi, illegal, q_flag},
            {59'd0, 1'b1, wr, wr && kind == 2, !legal, q_model});
        chk({req, " data {hi,lo}"}, {res_hi, res_lo}, {e_hi, e_lo});
    endtask

    task automatic clear_q();
        @(negedge clk);
        q_clear = 1'b1;
        @(negedge clk);
        q_clear = 1'b0;
        q_model = 1'b0;
        chk("R9 clear", {63'd0, q_flag}, 64'd0);
    endtask

    logic [15:0] vals [8] = '{16'h0000, 16'h0001, 16'hffff, 16'h7fff,
                              16'h8000, 16'h1234, 16'hedcb, 16'h0100};
    logic [31:0] accs [5] = '{32'h0, 32'h7fffffff, 32'h80000000, 32'hfffffff0, 32'h12345678};

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 reset outputs", {59'd0, res_valid, wr_lo, wr_hi, illegal, q_flag}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 idle no strobe", {63'd0, res_valid}, 64'd0);

        // Sweep: every form, both half selects, corner values (R1 R2 R3 R4)
        for (int k = 0; k < 3; k++)
            for (int x = 0; x < 2; x++)
                for (int y = 0; y < 2; y++) begin
                    clear_q();
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++) begin
                            logic [31:0] a, b;
                            a = x ? {vals[i], vals[i] ^ 16'h5a5a} : {vals[i] ^ 16'hc3c3, vals[i]};
                            b = y ? {vals[j], vals[j] ^ 16'h0ff0} : {vals[j] ^ 16'h3c3c, vals[j]};
                            txn(k == 0 ? "R1 R2 mul" : k == 1 ? "R1 R3 acc32" : "R1 R4 acc64",
                                mkw(opc_of(k), x[0], y[0], 4'd1, 4'd2, 4'd3, 4'd4), k,
                                a, b, accs[(i + j) % 5], accs[(i + 2*j) % 5], 1'b1, 1'b1);
                        end
                end

        // R5: condition failed, overflow-causing values
        clear_q();
        txn("R5 skip acc32", mkw(8'h10, 0, 0, 1, 2, 3, 4), 1,
            32'h00007fff, 32'h00007fff, 32'h7fffffff, 0, 1'b0, 1'b1);
        txn("R5 skip acc64", mkw(8'h14, 1, 1, 1, 2, 3, 4), 2,
            32'h12340000, 32'h56780000, 32'h1, 32'h2, 1'b0, 1'b1);
        txn("R5 skip mul", mkw(8'h16, 0, 1, 1, 2, 3, 4), 0,
            32'h5, 32'h70000, 0, 0, 1'b0, 1'b1);

        // R6: register 15 and equal pair destinations
        txn("R6 mul rd15", mkw(8'h16, 0, 0, 15, 0, 3, 4), 0, 3, 5, 0, 0, 1'b1, 1'b0);
        txn("R6 mul rm15", mkw(8'h16, 0, 0, 1, 0, 15, 4), 0, 3, 5, 0, 0, 1'b1, 1'b0);
        txn("R6 mul rn15", mkw(8'h16, 0, 0, 1, 0, 3, 15), 0, 3, 5, 0, 0, 1'b1, 1'b0);
        txn("R6 mul ra ignored", mkw(8'h16, 0, 0, 1, 15, 3, 4), 0, 3, 5, 0, 0, 1'b1, 1'b1);
        txn("R6 acc32 ra15 ovf", mkw(8'h10, 0, 0, 1, 15, 3, 4), 1,
            32'h7fff, 32'h7fff, 32'h7fffffff, 0, 1'b1, 1'b0);
        txn("R6 acc64 rd15", mkw(8'h14, 0, 0, 15, 2, 3, 4), 2, 3, 5, 1, 1, 1'b1, 1'b0);
        txn("R6 acc64 same dest", mkw(8'h14, 0, 0, 6, 6, 3, 4), 2, 3, 5, 1, 1, 1'b1, 1'b0);
        txn("R6 illegal cond low", mkw(8'h14, 0, 0, 6, 6, 3, 4), 2, 3, 5, 1, 1, 1'b0, 1'b0);

        // R7: malformed commands
        txn("R7 bad opcode", mkw(8'h12, 0, 0, 1, 2, 3, 4), 0, 3, 5, 0, 0, 1'b1, 1'b0);
        txn("R7 bit4 set", mkw(8'h16, 0, 0, 1, 2, 3, 4) | 28'h10, 0, 3, 5, 0, 0, 1'b1, 1'b0);
        txn("R7 bit7 clear", mkw(8'h16, 0, 0, 1, 2, 3, 4) & ~28'h80, 0, 3, 5, 0, 0, 1'b1, 1'b0);

        // R9: sticky after non-overflowing op, set wins over clear
        txn("R9 set", mkw(8'h10, 0, 0, 1, 2, 3, 4), 1,
            32'h7fff, 32'h7fff, 32'h7fffffff, 0, 1'b1, 1'b1);
        txn("R9 sticky", mkw(8'h10, 0, 0, 1, 2, 3, 4), 1, 2, 3, 4, 0, 1'b1, 1'b1);
        clear_q();
        @(negedge clk);
        op_fields = mkw(8'h10, 0, 0, 1, 2, 3, 4);
        opnd_a = 32'h7fff; opnd_b = 32'h7fff; acc_lo = 32'h7fffffff;
        cond_pass = 1'b1; in_valid = 1'b1; q_clear = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; q_clear = 1'b0;
        chk("R9 set beats clear", {63'd0, q_flag}, 64'd1);
        clear_q();

        // R8: back-to-back operations
        @(negedge clk);
        op_fields = mkw(8'h16, 0, 0, 1, 2, 3, 4);
        opnd_a = 32'h3; opnd_b = 32'h5; in_valid = 1'b1; cond_pass = 1'b1;
        @(negedge clk);
        chk("R8 first of pair", {31'd0, res_valid, res_lo}, {31'd0, 1'b1, 32'd15});
        opnd_a = 32'hfffe0000; op_fields = mkw(8'h16, 1, 0, 1, 2, 3, 4); opnd_b = 32'h7;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R8 second of pair", {31'd0, res_valid, res_lo}, {31'd0, 1'b1, 32'hfffffff2});
        @(negedge clk);
        chk("R8 strobe drops", {60'd0, res_valid, wr_lo, wr_hi, illegal}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule